// File: doc/BRIEF.md
# Gapped Serial Pattern Detector with Moore and Mealy Flags

This block watches a serial bit stream, one bit per clock, for the pattern "a 0, then a 1, then zero or more 0s, then a 1". A single six-state register tracks progress through the pattern. Two match flags are decoded from it. The registered flag is a function of the state alone, so it rises in the cycle after the closing 1. The combinational flag also looks at the live input, so it rises in the same cycle as the closing 1.

The two flags let a user trade latency against glitch-free, register-timed output. The state codes are chosen so that most transitions flip a single bit. The two codes the machine never uses steer back to the idle state on the next clock.

Top module: `gapped_det`

## Requirements
- R1: While rst_ni is low the state is idle (000). After reset release, with idle state, both z_moore_o and z_mealy_o are 0 for any x_i.
- R2: From idle (000), x_i=0 moves to seen-zero (001) and x_i=1 stays idle. From seen-zero, x_i=0 stays and x_i=1 moves to seen-one (011).
- R3: From seen-one (011), x_i=0 moves to gap (111) and x_i=1 moves to hit (010).
- R4: From gap (111), x_i=0 stays in gap for any number of cycles and x_i=1 moves to gap-hit (110).
- R5: From hit (010), x_i=0 moves to seen-zero and x_i=1 moves to idle. From gap-hit (110), x_i=0 moves to gap and x_i=1 moves to hit.
- R6: z_moore_o is 1 exactly when the state is hit or gap-hit, so it asserts one cycle after the closing 1 of a match.
- R7: z_mealy_o is 1 exactly when x_i=1 while the state is seen-one or gap, in the same cycle as that input. It is 0 in hit and in gap-hit.
- R8: The codes 100 and 101 are never held. If one were reached, the next state is idle, and both flags are 0 while it is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 1 | Serial data bit, one per cycle |
| z_moore_o | output | 1 | Registered match flag, one cycle after the closing bit |
| z_mealy_o | output | 1 | Combinational match flag, same cycle as the closing bit |

## Verification
The checker watches several things on every cycle. A rising combinational flag is always followed by the registered flag in the next cycle. The combinational flag stays low in both success states. The unused codes never appear. The individual transitions out of the seen-one and gap states hold. Only the bench's scenarios can show the following: that the full pattern is found after long runs of zeros, that overlapping matches behave as stated, that the quoted timing stream gives the expected flags, and that a reset in the middle of a pattern discards the partial match.

// File: rtl/gapped_det_pkg.sv
package gapped_det_pkg;
  localparam int unsigned StateW = 3;

  // Gray-like codes: most arcs flip one bit
  typedef enum logic [StateW-1:0] {
    ST_IDLE    = 3'b000,
    ST_ZERO    = 3'b001,
    ST_ONE     = 3'b011,
    ST_HIT     = 3'b010,
    ST_GAP     = 3'b111,
    ST_GAP_HIT = 3'b110
  } det_state_e;
endpackage

// File: rtl/gapped_det_next.sv
module gapped_det_next
  import gapped_det_pkg::*;
(
  input  logic [StateW-1:0] state_i,
  input  logic              x_i,
  output logic [StateW-1:0] state_nxt_o
);
  always_comb begin
    unique case (state_i)
      ST_IDLE:    state_nxt_o = x_i ? ST_IDLE : ST_ZERO;
      ST_ZERO:    state_nxt_o = x_i ? ST_ONE  : ST_ZERO;
      ST_ONE:     state_nxt_o = x_i ? ST_HIT  : ST_GAP;
      ST_GAP:     state_nxt_o = x_i ? ST_GAP_HIT : ST_GAP;
      ST_HIT:     state_nxt_o = x_i ? ST_IDLE : ST_ZERO;
      ST_GAP_HIT: state_nxt_o = x_i ? ST_HIT  : ST_GAP;
      default:    state_nxt_o = ST_IDLE; // unused codes recover
    endcase
  end
endmodule

// File: rtl/gapped_det_out.sv
module gapped_det_out
  import gapped_det_pkg::*;
(
  input  logic [StateW-1:0] state_i,
  input  logic              x_i,
  output logic              z_moore_o,
  output logic              z_mealy_o
);
  always_comb begin
    z_moore_o = 1'b0;
    z_mealy_o = 1'b0;
    unique case (state_i)
      ST_HIT, ST_GAP_HIT: z_moore_o = 1'b1;
      ST_ONE, ST_GAP:     z_mealy_o = x_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/gapped_det.sv
module gapped_det
  import gapped_det_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic z_moore_o,
  output logic z_mealy_o
);
  logic [StateW-1:0] state_q;
  logic [StateW-1:0] state_d;

  gapped_det_next u_next (
    .state_i     (state_q),
    .x_i         (x_i),
    .state_nxt_o (state_d)
  );

  gapped_det_out u_out (
    .state_i   (state_q),
    .x_i       (x_i),
    .z_moore_o (z_moore_o),
    .z_mealy_o (z_mealy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/gapped_det_chk.sv
module gapped_det_chk
  import gapped_det_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              x_i,
  input logic              z_moore_o,
  input logic              z_mealy_o,
  input logic [StateW-1:0] state_q
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!z_moore_o && !z_mealy_o));

  p_one_to_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ONE && x_i) |=> (state_q == ST_HIT));

  p_one_to_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ONE && !x_i) |=> (state_q == ST_GAP));

  p_gap_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP && !x_i) |=> (state_q == ST_GAP));

  p_hit_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIT && x_i) |=> (state_q == ST_IDLE));

  p_mealy_leads_moore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_mealy_o |=> z_moore_o);

  p_mealy_low_success_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIT || state_q == ST_GAP_HIT) |-> !z_mealy_o);

  p_no_unused_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state_q[2] && !state_q[1]));
endmodule

bind gapped_det gapped_det_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .x_i       (x_i),
  .z_moore_o (z_moore_o),
  .z_mealy_o (z_mealy_o),
  .state_q   (state_q)
);

// File: tb/gapped_det_tb_top.sv
`timescale 1ns/1ps
module gapped_det_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x = 1'b0;
  logic z_moore, z_mealy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Model progress: 0 idle,1 seen 0,2 seen 01,3 in gap,4 hit,5 gap hit
  int mdl = 0;

  always #2 clk = ~clk;

  gapped_det dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .x_i       (x),
    .z_moore_o (z_moore),
    .z_mealy_o (z_mealy)
  );

  function automatic string tag_of(int p);
    case (p)
      0, 1:    return "R2";
      2:       return "R3";
      3:       return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic int next_of(int p, bit b);
    if (p == 0)      return b ? 0 : 1;
    else if (p == 1) return b ? 2 : 1;
    else if (p == 2) return b ? 4 : 3;
    else if (p == 3) return b ? 5 : 3;
    else if (p == 4) return b ? 0 : 1;
    else             return b ? 4 : 3;
  endfunction

  task automatic check(string req, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Called at a negedge: drive bit, check both flags around the next edge
  task automatic step(bit b);
    string tr;
    bit exp_mealy;
    tr = tag_of(mdl);
    x = b;
    #1;
    exp_mealy = b && (mdl == 2 || mdl == 3);
    check({"R7 via ", tr}, z_mealy, exp_mealy);
    mdl = next_of(mdl, b);
    @(negedge clk);
    check({"R6 via ", tr}, z_moore, (mdl == 4 || mdl == 5));
  endtask

  task automatic run(bit seq[$]);
    foreach (seq[i]) step(seq[i]);
  endtask

  initial begin
    bit s[$];
    x = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 moore in reset", z_moore, 1'b0);
    check("R1 mealy in reset", z_mealy, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    mdl = 0;
    #1;
    check("R1 mealy idle x=1", z_mealy, 1'b0);
    check("R1 moore idle", z_moore, 1'b0);

    // timing stream, R6/R7
    s = '{1,0,0,1,0,0,1,0,1,1,1,0};
    run(s);

    // long gap, R4
    s = '{0,1};
    run(s);
    for (int i = 0; i < 40; i++) step(1'b0);
    step(1'b1);
    step(1'b0);
    step(1'b1);

    // direct 011, success exits, R3/R5
    s = '{0,0,1,1,1,0,1,1,0,1,0,0,1,1,0,1,0,1,1};
    run(s);

    // reset mid-pattern, R1
    s = '{0,1,0,0};
    run(s);
    rst_n = 1'b0;
    #1;
    check("R1 moore async reset", z_moore, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    mdl = 0;
    x = 1'b1;
    #1;
    check("R1 mealy after mid reset", z_mealy, 1'b0);
    @(negedge clk);
    mdl = next_of(mdl, 1'b1);
    check("R1 moore after mid reset", z_moore, 1'b0);

    // pseudo-random stream
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] & (lfsr[3] | lfsr[5]));
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule